// File: doc/BRIEF.md
# Byte-Lane Pseudo-Static RAM Device Emulator

This block is a synthesizable, clocked stand-in for an asynchronous pseudo-static RAM. It serves as the target memory when a host controller is verified in simulation or on an emulation platform. The block samples the active-low chip select, write strobe, output strobe and two byte-lane enables, plus an active-high power control, on a free-running sample clock. It decodes them into deselect, read, write and high-Z modes for each of the two byte lanes.

Storage is a parameterized word array with one valid bit per lane of each word. Each byte lane is gated independently. Pulling the power control low enters power-down, which drops the stored contents. Any lane not rewritten since then reads back an all-ones poison byte. The tristate data bus is modelled as a data-out vector plus one output-enable bit per lane. A built-in protocol checker flags chip-select low pulses that are too short while a write is in progress.

Top module: `psram_lane_emu`

## Requirements
- R1: After reset, `rdata_oe` is 0 and `seq_err` is 0.
- R2: When `chip_sel_n` is high, or `chip_pwr` is low, or both bits of `lane_en_n` are high, both lanes are undriven (`rdata_oe` = 0) and nothing is stored.
- R3: A read drives lane i (`rdata_oe[i]` = 1) only while `chip_sel_n` = 0, `chip_pwr` = 1, `out_en_n` = 0, `wr_en_n` = 1 and `lane_en_n[i]` = 0. The lane's stored byte appears on `rdata`. Outputs reflect the inputs sampled at the previous rising clock edge.
- R4: A lane is stored in every sampled cycle with `chip_sel_n` = 0, `chip_pwr` = 1, `wr_en_n` = 0 and that lane's enable low, whatever `out_en_n` is. Both lanes stay undriven during a write. The other lane's stored byte is unchanged.
- R5: With `chip_sel_n` = 0 and `chip_pwr` = 1, but both `out_en_n` and `wr_en_n` high, both lanes are undriven and nothing is stored.
- R6: `lane_en_n[0]` gates data bits 7:0 and `lane_en_n[1]` gates data bits 15:8.
- R7: Any cycle with `chip_pwr` low invalidates every stored byte. A read of a lane not rewritten since then returns 8'hFF for that lane. Standby (`chip_sel_n` high, `chip_pwr` high) keeps the contents.
- R8: After reset, every lane of every word reads as 8'hFF until it is written.
- R9: A chip-select low run shorter than ceil(MIN_CE_NS / CLK_NS) sample cycles, with `wr_en_n` sampled low at some point in it, raises `seq_err` for exactly one cycle. The pulse comes two rising edges after the edge that first samples `chip_sel_n` high again.
- R10: A chip-select low run of at least ceil(MIN_CE_NS / CLK_NS) cycles, or a shorter run with no write sampled in it, leaves `seq_err` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running sample clock, period CLK_NS |
| rst_n | input | 1 | Asynchronous active-low reset |
| chip_sel_n | input | 1 | Active-low chip select |
| chip_pwr | input | 1 | Active-high power control; low enters power-down |
| wr_en_n | input | 1 | Active-low write strobe |
| out_en_n | input | 1 | Active-low output strobe |
| lane_en_n | input | 2 | Active-low byte-lane enables, bit 0 low byte |
| addr | input | ADDR_W | Word address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data; a lane is zero when not driven |
| rdata_oe | output | 2 | Per-lane output enable (1 = lane driven) |
| seq_err | output | 1 | One-cycle flag for a short chip-select pulse with a write |

## Verification
The bench builds the block with ADDR_W = 6, CLK_NS = 10 and MIN_CE_NS = 30. This gives a minimum chip-select run of three cycles, so both sides of the short-pulse threshold are reached: a two-cycle write pulse is flagged and a three-cycle one is not. The 64-word depth keeps the reference model small. It still lets a power-down clear words written earlier, and lets a partial rewrite show poison on the lane that was not rewritten.

// File: rtl/psram_emu_pkg.sv
package psram_emu_pkg;
  localparam int LANES  = 2;
  localparam int LANE_W = 8;
  localparam int DATA_W = LANES * LANE_W;

  typedef struct packed {
    logic             cs_n;
    logic             pwr;
    logic             we_n;
    logic             oe_n;
    logic [LANES-1:0] ben_n;
  } ctl_t;

  localparam ctl_t CTL_IDLE = '{cs_n: 1'b1, pwr: 1'b1, we_n: 1'b1,
                                oe_n: 1'b1, ben_n: '1};
endpackage

// File: rtl/psram_rst_sync.sv
module psram_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/psram_mode_decode.sv
module psram_mode_decode
  import psram_emu_pkg::*;
(
  input  ctl_t             ctl,
  output logic [LANES-1:0] rd_lane,
  output logic [LANES-1:0] wr_lane,
  output logic             pwr_down
);
  logic selected;

  assign selected = !ctl.cs_n && ctl.pwr;
  assign pwr_down = !ctl.pwr;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign rd_lane[l] = selected && !ctl.oe_n && ctl.we_n && !ctl.ben_n[l];
    assign wr_lane[l] = selected && !ctl.we_n && !ctl.ben_n[l];
  end
endmodule

// File: rtl/psram_lane_store.sv
module psram_lane_store #(
  parameter int ADDR_W = 8,
  parameter int W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              clr_all,
  input  logic [ADDR_W-1:0] addr,
  input  logic [W-1:0]      wdata,
  output logic [W-1:0]      rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [W-1:0]     mem_q [DEPTH];
  logic [DEPTH-1:0] vld_d, vld_q;

  always_comb begin
    vld_d = vld_q;
    if (clr_all)    vld_d = '0;
    else if (wr_en) vld_d[addr] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem_q[addr] <= wdata;
  end

  assign rdata = vld_q[addr] ? mem_q[addr] : {W{1'b1}};

  // R7
  poison_after_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(clr_all) |-> (rdata == {W{1'b1}}));
endmodule

// File: rtl/psram_ce_pulse_chk.sv
module psram_ce_pulse_chk #(
  parameter int CLK_NS    = 10,
  parameter int MIN_CE_NS = 30
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic we_n,
  output logic err
);
  localparam int MIN_CYC = (MIN_CE_NS + CLK_NS - 1) / CLK_NS;
  localparam int CW      = $clog2(MIN_CYC + 2);
  localparam logic [CW-1:0] MIN_CNT = CW'(MIN_CYC);

  logic          cs_prev_d, cs_prev_q;
  logic [CW-1:0] cnt_d, cnt_q;
  logic          wr_d, wr_q;
  logic          err_d, err_q;
  logic          cs_rise;

  assign cs_rise = cs_n && !cs_prev_q;

  always_comb begin
    cs_prev_d = cs_n;
    if (!cs_n) begin
      cnt_d = (cnt_q >= MIN_CNT) ? cnt_q : cnt_q + 1'b1;
      wr_d  = wr_q || !we_n;
    end else begin
      cnt_d = '0;
      wr_d  = 1'b0;
    end
    err_d = cs_rise && wr_q && (cnt_q < MIN_CNT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_prev_q <= 1'b1;
      cnt_q     <= '0;
      wr_q      <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      cs_prev_q <= cs_prev_d;
      cnt_q     <= cnt_d;
      wr_q      <= wr_d;
      err_q     <= err_d;
    end
  end

  assign err = err_q;

  // R10
  long_run_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise && cnt_q >= MIN_CNT) |=> !err);
endmodule

// File: rtl/psram_lane_emu.sv
module psram_lane_emu
  import psram_emu_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int CLK_NS    = 10,
  parameter int MIN_CE_NS = 30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chip_sel_n,
  input  logic              chip_pwr,
  input  logic              wr_en_n,
  input  logic              out_en_n,
  input  logic [LANES-1:0]  lane_en_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [LANES-1:0]  rdata_oe,
  output logic              seq_err
);
  logic              rst_sync_n;
  ctl_t              ctl_d, ctl_q;
  logic [ADDR_W-1:0] addr_d, addr_q;
  logic [DATA_W-1:0] wd_d, wd_q;
  logic [LANES-1:0]  rd_lane, wr_lane;
  logic              pwr_down;

  psram_rst_sync i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  // input sampling: next state
  always_comb begin
    ctl_d.cs_n  = chip_sel_n;
    ctl_d.pwr   = chip_pwr;
    ctl_d.we_n  = wr_en_n;
    ctl_d.oe_n  = out_en_n;
    ctl_d.ben_n = lane_en_n;
    addr_d      = addr;
    wd_d        = wdata;
  end

  // input sampling: registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      ctl_q  <= CTL_IDLE;
      addr_q <= '0;
      wd_q   <= '0;
    end else begin
      ctl_q  <= ctl_d;
      addr_q <= addr_d;
      wd_q   <= wd_d;
    end
  end

  psram_mode_decode i_decode (
    .ctl      (ctl_q),
    .rd_lane  (rd_lane),
    .wr_lane  (wr_lane),
    .pwr_down (pwr_down)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_store
    logic [LANE_W-1:0] lane_rd;

    psram_lane_store #(.ADDR_W(ADDR_W), .W(LANE_W)) i_store (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .wr_en   (wr_lane[l]),
      .clr_all (pwr_down),
      .addr    (addr_q),
      .wdata   (wd_q[l*LANE_W +: LANE_W]),
      .rdata   (lane_rd)
    );

    assign rdata[l*LANE_W +: LANE_W] = rd_lane[l] ? lane_rd : '0;
  end

  assign rdata_oe = rd_lane;

  psram_ce_pulse_chk #(.CLK_NS(CLK_NS), .MIN_CE_NS(MIN_CE_NS)) i_pulse_chk (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .cs_n  (ctl_q.cs_n),
    .we_n  (ctl_q.we_n),
    .err   (seq_err)
  );

  // R2
  deselect_hiz_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (chip_sel_n || !chip_pwr || (&lane_en_n)) |=> (rdata_oe == '0));

  // R3
  read_lane_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!chip_sel_n && chip_pwr && !out_en_n && wr_en_n) |=> (rdata_oe == ~$past(lane_en_n)));

  // R4
  write_hiz_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!chip_sel_n && chip_pwr && !wr_en_n) |=> (rdata_oe == '0));

  // R5
  idle_hiz_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!chip_sel_n && chip_pwr && wr_en_n && out_en_n) |=> (rdata_oe == '0));

  // R9
  err_single_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    seq_err |=> !seq_err);

  // R9
  err_after_rise_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    seq_err |-> $past(chip_sel_n, 2));
endmodule

// File: tb/test_psram_lane_emu.sv
module test_psram_lane_emu;
  localparam int CLK_PERIOD = 10;
  localparam int AW         = 6;
  localparam int DEPTH      = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          chip_sel_n, chip_pwr, wr_en_n, out_en_n;
  logic [1:0]    lane_en_n;
  logic [AW-1:0] addr;
  logic [15:0]   wdata, rdata;
  logic [1:0]    rdata_oe;
  logic          seq_err;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int err_seen = 0;

  typedef struct {
    int          due;
    logic [1:0]  oe;
    logic [15:0] data;
    string       req;
  } exp_t;
  exp_t q[$];

  logic [15:0] m_data [DEPTH];
  logic [1:0]  m_vld  [DEPTH];

  psram_lane_emu #(.ADDR_W(AW), .CLK_NS(10), .MIN_CE_NS(30)) i_psram_lane_emu (
    .clk(clk), .rst_n(rst_n), .chip_sel_n(chip_sel_n), .chip_pwr(chip_pwr),
    .wr_en_n(wr_en_n), .out_en_n(out_en_n), .lane_en_n(lane_en_n), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe), .seq_err(seq_err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) if (seq_err === 1'b1) err_seen <= err_seen + 1;

  // monitor: pops expected items and compares them with the outputs
  always @(negedge clk) begin
    if (q.size() > 0 && q[0].due == cyc) begin
      exp_t it;
      logic [15:0] mask;
      it = q.pop_front();
      mask = {{8{it.oe[1]}}, {8{it.oe[0]}}};
      checks++;
      if (rdata_oe !== it.oe || (rdata & mask) !== (it.data & mask)) begin
        failures++;
        $display("FAIL %s: oe=%b data=%h expected oe=%b data=%h",
                 it.req, rdata_oe, rdata & mask, it.oe, it.data & mask);
      end
    end
  end

  function automatic logic [15:0] model_read(int a);
    logic [15:0] r;
    for (int l = 0; l < 2; l++)
      r[l*8 +: 8] = m_vld[a][l] ? m_data[a][l*8 +: 8] : 8'hFF;
    return r;
  endfunction

  task automatic check_val(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic go_idle();
    @(negedge clk);
    chip_sel_n = 1'b1; chip_pwr = 1'b1; wr_en_n = 1'b1; out_en_n = 1'b1;
    lane_en_n = 2'b11;
  endtask

  // drive one cycle and push the expected lane enables/data
  task automatic drive(logic cs, logic pw, logic we, logic oe, logic [1:0] be,
                       int a, logic [15:0] d, logic [1:0] eoe, logic [15:0] ed,
                       string req);
    @(negedge clk);
    chip_sel_n = cs; chip_pwr = pw; wr_en_n = we; out_en_n = oe;
    lane_en_n = be; addr = AW'(a); wdata = d;
    q.push_back('{cyc + 1, eoe, ed, req});
  endtask

  task automatic model_write(int a, logic [1:0] be, logic [15:0] d);
    for (int l = 0; l < 2; l++)
      if (!be[l]) begin
        m_data[a][l*8 +: 8] = d[l*8 +: 8];
        m_vld[a][l] = 1'b1;
      end
  endtask

  // three-cycle chip-select run with the write in the middle cycle
  task automatic wr(int a, logic [1:0] be, logic [15:0] d, logic oe);
    drive(1'b0, 1'b1, 1'b1, oe, 2'b11, a, d, 2'b00, 16'h0, "R5");
    drive(1'b0, 1'b1, 1'b0, oe, be, a, d, 2'b00, 16'h0, "R4");
    model_write(a, be, d);
    drive(1'b0, 1'b1, 1'b1, oe, 2'b11, a, d, 2'b00, 16'h0, "R4");
    go_idle();
  endtask

  task automatic rd(int a, logic [1:0] be, string req);
    drive(1'b0, 1'b1, 1'b1, 1'b0, be, a, 16'h0, ~be, model_read(a), req);
    go_idle();
  endtask

  task automatic settle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    failures++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int base;
    for (int i = 0; i < DEPTH; i++) begin m_data[i] = '0; m_vld[i] = 2'b00; end
    rst_n = 1'b0; chip_sel_n = 1'b1; chip_pwr = 1'b1; wr_en_n = 1'b1;
    out_en_n = 1'b1; lane_en_n = 2'b11; addr = '0; wdata = '0;
    settle(3);
    rst_n = 1'b1;
    settle(4);
    check_val("R1 oe", int'(rdata_oe), 0);
    check_val("R1 err", int'(seq_err), 0);

    rd(3, 2'b00, "R8 poison after reset");
    wr(5, 2'b00, 16'hA55A, 1'b0);              // OE low during write (R4)
    rd(5, 2'b00, "R3 full read");
    wr(5, 2'b10, 16'h1234, 1'b1);              // low lane only (R6)
    rd(5, 2'b00, "R6 low lane write");
    wr(5, 2'b01, 16'hBEEF, 1'b1);              // high lane only (R6)
    rd(5, 2'b00, "R6 high lane write");
    rd(5, 2'b10, "R6 low lane read");
    rd(5, 2'b01, "R6 high lane read");

    drive(1'b0, 1'b1, 1'b1, 1'b1, 2'b00, 5, 16'h0, 2'b00, 16'h0, "R5 idle hiz");
    go_idle();

    wr(6, 2'b00, 16'h1111, 1'b1);
    drive(1'b1, 1'b1, 1'b0, 1'b0, 2'b00, 6, 16'h0, 2'b00, 16'h0, "R2 cs high");
    go_idle();
    for (int i = 0; i < 3; i++)
      drive(1'b0, 1'b1, 1'b0, 1'b1, 2'b11, 6, 16'h0, 2'b00, 16'h0, "R2 lanes off");
    go_idle();
    rd(6, 2'b00, "R2 no write");

    settle(5);                                  // standby
    rd(5, 2'b00, "R7 standby keeps");

    drive(1'b0, 1'b0, 1'b1, 1'b0, 2'b00, 5, 16'h0, 2'b00, 16'h0, "R2 pwr low");
    for (int i = 0; i < DEPTH; i++) m_vld[i] = 2'b00;
    go_idle();
    rd(5, 2'b00, "R7 poison after power-down");
    wr(7, 2'b10, 16'h0042, 1'b1);
    rd(7, 2'b00, "R7 partial rewrite");

    settle(3);
    base = err_seen;
    drive(1'b0, 1'b1, 1'b1, 1'b1, 2'b11, 9, 16'h5151, 2'b00, 16'h0, "R5");
    drive(1'b0, 1'b1, 1'b0, 1'b1, 2'b00, 9, 16'h5151, 2'b00, 16'h0, "R4");
    model_write(9, 2'b00, 16'h5151);
    go_idle();
    settle(5);
    check_val("R9 short write pulse", err_seen - base, 1);
    rd(9, 2'b00, "R4 short pulse stored");

    settle(3);
    base = err_seen;
    wr(10, 2'b00, 16'h7777, 1'b1);
    settle(5);
    check_val("R10 min-length write pulse", err_seen - base, 0);
    rd(10, 2'b00, "R10 read-only short pulse");
    settle(5);
    check_val("R10 read pulse quiet", err_seen - base, 0);

    settle(4);
    check_val("R3 queue drained", q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule